// File: doc/BRIEF.md
# Clock-Sweep Victim Frame Selector

This block chooses which physical frame to evict when a new page has to be brought in. For every frame it keeps a "recently referenced" flag and a "modified" flag. Any access to a frame sets its referenced flag, and a write access also sets its modified flag. A circular pointer sweeps over the frames to find a victim. As it passes a referenced frame, it clears that frame's flag, which gives the frame a second chance. The first frame it reaches with the flag already clear becomes the victim.

The block has two search modes, chosen for each request. The plain mode runs the second-chance sweep described above. The clean-first mode first makes one full pass without clearing anything, looking for a frame that is neither referenced nor modified. Only if no such frame exists does it fall back to the plain sweep. The result is the victim's index, a flag that says whether the victim must be written back, and a one-cycle done pulse. The pointer then moves one past the victim, and the victim's flags are cleared for the page that will replace it.

Top module: `nru_victim_picker`

## Requirements
- R1: After reset, every referenced and modified flag is 0, the sweep pointer is at frame 0, and `victimDone` and `busy` are low.
- R2: An access sets the referenced flag of frame `accIdx`. When `accWrite` is 1, the access also sets that frame's modified flag, and `victimDirty` later reports this flag.
- R3: In plain mode (`preferClean`=0), the sweep examines one frame per clock, starting at the pointer. It clears the referenced flag of each referenced frame and moves on. It selects the first frame whose referenced flag is already 0.
- R4: The pointer wraps from frame NUM_FRAMES-1 to frame 0. After a victim is chosen, the pointer stands one frame past it, and the next search starts there.
- R5: In clean-first mode (`preferClean`=1), the sweep first examines NUM_FRAMES frames without clearing any flag and selects the first frame that is both unreferenced and unmodified. If it finds none, it runs the plain sweep of R3 from the same starting frame. No search examines more than 2*NUM_FRAMES+1 frames.
- R6: When a search examines k frames and the request is sampled at clock edge E, `victimDone` is high for exactly one cycle after edge E+k. During that cycle, `victimIdx` and `victimDirty` give the victim and its modified flag as they were before selection.
- R7: When a victim is selected, its referenced and modified flags are cleared.
- R8: When an access and a sweep clear hit the same frame in the same cycle, the access wins and the referenced flag stays 1.
- R9: `reqValid` is ignored while `busy` is high. It neither restarts the search nor adds a second done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| accValid | input | 1 | Frame access strobe |
| accIdx | input | $clog2(NUM_FRAMES) | Index of the accessed frame |
| accWrite | input | 1 | Access is a write (sets modified flag) |
| reqValid | input | 1 | Victim request, sampled while idle |
| preferClean | input | 1 | 1 = clean-first search, 0 = plain sweep |
| busy | output | 1 | Search in progress |
| victimDone | output | 1 | One-cycle pulse: victim result valid |
| victimIdx | output | $clog2(NUM_FRAMES) | Selected frame index |
| victimDirty | output | 1 | Selected frame needs write-back |

## Verification
The assertions assume that `accIdx` names an existing frame whenever `accValid` is high. They also assume that the outputs of a finished search are consumed in the cycle of the done pulse. The stimulus therefore uses only in-range indices and reads the result on the pulse. Accesses come between searches so that the bench's flag model stays exact. Two exceptions are made on purpose. In the collision case, one access lands on the frame under the pointer in the cycle that frame is being cleared. In the busy case, one extra request pulse arrives in the middle of a search.

// File: rtl/nru_pkg.sv
package nru_pkg;
  typedef struct packed {
    logic clrRef;   // clear referenced flag of frame under pointer
    logic advance;  // move pointer forward without selecting
    logic commit;   // select frame under pointer as victim
  } sweepStrobes_t;
endpackage

// File: rtl/nru_sweep_ctrl.sv
module nru_sweep_ctrl
  import nru_pkg::*;
#(
  parameter int NUM_FRAMES = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          reqValid,
  input  logic          preferClean,
  input  logic          curRef,
  input  logic          curDirty,
  output sweepStrobes_t strb,
  output logic          busy
);
  localparam int CNT_W = $clog2(NUM_FRAMES) + 1;
  localparam logic [CNT_W-1:0] PASS_LAST = CNT_W'(NUM_FRAMES - 1);

  typedef enum logic {ST_IDLE, ST_SCAN} ctrlState_t;

  ctrlState_t stateQ;
  logic       cleanPassQ;
  logic [CNT_W-1:0] passCntQ;

  assign busy = (stateQ == ST_SCAN);

  always_comb begin
    strb = '0;
    if (stateQ == ST_SCAN) begin
      if (cleanPassQ) begin
        if (!curRef && !curDirty) strb.commit  = 1'b1;
        else                      strb.advance = 1'b1;
      end else if (curRef) begin
        strb.clrRef  = 1'b1;
        strb.advance = 1'b1;
      end else begin
        strb.commit = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ     <= ST_IDLE;
      cleanPassQ <= 1'b0;
      passCntQ   <= '0;
    end else begin
      case (stateQ)
        ST_IDLE: if (reqValid) begin
          stateQ     <= ST_SCAN;
          cleanPassQ <= preferClean;
          passCntQ   <= '0;
        end
        default: begin
          if (strb.commit) begin
            stateQ <= ST_IDLE;
          end else if (cleanPassQ) begin
            if (passCntQ == PASS_LAST) cleanPassQ <= 1'b0;
            else                       passCntQ   <= passCntQ + 1'b1;
          end
        end
      endcase
    end
  end

  // Checker-only count of frames examined in the current search.
  logic [CNT_W:0] examCntQ;
  always_ff @(posedge clk) begin
    if (!rstN)                              examCntQ <= '0;
    else if (stateQ == ST_IDLE && reqValid) examCntQ <= '0;
    else if (stateQ == ST_SCAN)             examCntQ <= examCntQ + 1'b1;
  end

  // R5: search bounded to 2*NUM_FRAMES+1 examinations
  a_r5_search_bounded: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (examCntQ <= (CNT_W+1)'(2*NUM_FRAMES)));

  // R9: a request seen while busy does not reset the examination count
  a_r9_busy_ignores_req: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !strb.commit) |=> (busy && examCntQ == $past(examCntQ) + 1'b1));
endmodule

// File: rtl/nru_flag_store.sv
module nru_flag_store
  import nru_pkg::*;
#(
  parameter int NUM_FRAMES = 16
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          accValid,
  input  logic [$clog2(NUM_FRAMES)-1:0] accIdx,
  input  logic                          accWrite,
  input  sweepStrobes_t                 strb,
  output logic                          curRef,
  output logic                          curDirty,
  output logic                          victimDone,
  output logic [$clog2(NUM_FRAMES)-1:0] victimIdx,
  output logic                          victimDirty
);
  localparam int IDX_W = $clog2(NUM_FRAMES);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_FRAMES - 1);

  logic [NUM_FRAMES-1:0] refBits;
  logic [NUM_FRAMES-1:0] dirtyBits;
  logic [IDX_W-1:0]      ptrQ;
  logic [IDX_W-1:0]      ptrNext;

  assign curRef   = refBits[ptrQ];
  assign curDirty = dirtyBits[ptrQ];
  assign ptrNext  = (ptrQ == LAST) ? '0 : ptrQ + 1'b1;

  for (genvar g = 0; g < NUM_FRAMES; g++) begin : g_frame
    logic hitAcc;
    logic atPtr;
    assign hitAcc = accValid && (accIdx == IDX_W'(g));
    assign atPtr  = (ptrQ == IDX_W'(g));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        refBits[g]   <= 1'b0;
        dirtyBits[g] <= 1'b0;
      end else begin
        // access has priority over sweep clear and victim clear
        if (hitAcc)                                refBits[g] <= 1'b1;
        else if (atPtr && (strb.clrRef || strb.commit)) refBits[g] <= 1'b0;
        if (hitAcc && accWrite)                    dirtyBits[g] <= 1'b1;
        else if (atPtr && strb.commit)             dirtyBits[g] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptrQ        <= '0;
      victimDone  <= 1'b0;
      victimIdx   <= '0;
      victimDirty <= 1'b0;
    end else begin
      victimDone <= strb.commit;
      if (strb.advance || strb.commit) ptrQ <= ptrNext;
      if (strb.commit) begin
        victimIdx   <= ptrQ;
        victimDirty <= curDirty;
      end
    end
  end

  // R4: pointer steps by one with wrap, and holds otherwise
  a_r4_ptr_step: assert property (@(posedge clk) disable iff (!rstN)
    (strb.advance || strb.commit) |=>
      (ptrQ == (($past(ptrQ) == LAST) ? '0 : $past(ptrQ) + 1'b1)));
  a_r4_ptr_hold: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.advance || strb.commit) |=> $stable(ptrQ));

  // R6: done is a single-cycle pulse
  a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    victimDone |=> !victimDone);

  // R7: victim flags cleared unless an access hits it in the same cycle
  a_r7_victim_cleared: assert property (@(posedge clk) disable iff (!rstN)
    (strb.commit && !(accValid && accIdx == ptrQ)) |=>
      (!refBits[$past(ptrQ)] && !dirtyBits[$past(ptrQ)]));

  // R8: access wins over sweep clear
  a_r8_access_wins: assert property (@(posedge clk) disable iff (!rstN)
    (strb.clrRef && accValid && accIdx == ptrQ) |=> refBits[$past(accIdx)]);
endmodule

// File: rtl/nru_victim_picker.sv
module nru_victim_picker
  import nru_pkg::*;
#(
  parameter int NUM_FRAMES = 16
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          accValid,
  input  logic [$clog2(NUM_FRAMES)-1:0] accIdx,
  input  logic                          accWrite,
  input  logic                          reqValid,
  input  logic                          preferClean,
  output logic                          busy,
  output logic                          victimDone,
  output logic [$clog2(NUM_FRAMES)-1:0] victimIdx,
  output logic                          victimDirty
);
  sweepStrobes_t strb;
  logic curRef;
  logic curDirty;

  nru_sweep_ctrl #(.NUM_FRAMES(NUM_FRAMES)) ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .preferClean(preferClean),
    .curRef     (curRef),
    .curDirty   (curDirty),
    .strb       (strb),
    .busy       (busy)
  );

  nru_flag_store #(.NUM_FRAMES(NUM_FRAMES)) store_i (
    .clk        (clk),
    .rstN       (rstN),
    .accValid   (accValid),
    .accIdx     (accIdx),
    .accWrite   (accWrite),
    .strb       (strb),
    .curRef     (curRef),
    .curDirty   (curDirty),
    .victimDone (victimDone),
    .victimIdx  (victimIdx),
    .victimDirty(victimDirty)
  );
endmodule

// File: tb/nru_victim_picker_tb.sv
module nru_victim_picker_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N = 8;
  localparam int IW = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic accValid = 1'b0;
  logic [IW-1:0] accIdx = '0;
  logic accWrite = 1'b0;
  logic reqValid = 1'b0;
  logic preferClean = 1'b0;
  logic busy, victimDone, victimDirty;
  logic [IW-1:0] victimIdx;

  int nChecks = 0;
  int nFails = 0;
  int mRef[N];
  int mDirty[N];
  int mPtr = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nru_victim_picker #(.NUM_FRAMES(N)) dut_i (
    .clk(clk), .rstN(rstN), .accValid(accValid), .accIdx(accIdx),
    .accWrite(accWrite), .reqValid(reqValid), .preferClean(preferClean),
    .busy(busy), .victimDone(victimDone), .victimIdx(victimIdx),
    .victimDirty(victimDirty)
  );

  task automatic check(string req, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic doAccess(int idx, bit wr);
    accValid = 1'b1; accIdx = IW'(idx); accWrite = wr;
    step();
    accValid = 1'b0; accWrite = 1'b0;
    mRef[idx] = 1;
    if (wr) mDirty[idx] = 1;
  endtask

  // Model of one search; returns victim, its dirty flag and frames examined.
  task automatic model(bit clean, output int v, output int d, output int k);
    int p = mPtr;
    v = -1; k = 0;
    if (clean) begin
      for (int i = 0; i < N; i++) begin
        int f = (p + i) % N;
        if (mRef[f] == 0 && mDirty[f] == 0) begin v = f; k = i + 1; break; end
      end
    end
    if (v < 0) begin
      for (int j = 0; j <= N; j++) begin
        int f = (p + j) % N;
        if (mRef[f] != 0) mRef[f] = 0;
        else begin v = f; k = (clean ? N : 0) + j + 1; break; end
      end
    end
    d = mDirty[v];
    mRef[v] = 0; mDirty[v] = 0; mPtr = (v + 1) % N;
  endtask

  task automatic waitDone(output int cnt);
    cnt = 1;
    while (!victimDone && cnt < 4*N + 4) begin step(); cnt++; end
  endtask

  task automatic doPick(bit clean);
    int v, d, k, cnt;
    model(clean, v, d, k);
    reqValid = 1'b1; preferClean = clean;
    step();
    reqValid = 1'b0;
    waitDone(cnt);
    if (clean) check("R5 victim index", int'(victimIdx), v);
    else       check("R3 victim index", int'(victimIdx), v);
    check("R2 victim dirty flag", int'(victimDirty), d);
    check("R6 cycles to done", cnt, k + 1);
    step();
    check("R6 done single pulse", int'(victimDone), 0);
  endtask

  initial begin
    int cnt, p;
    for (int i = 0; i < N; i++) begin mRef[i] = 0; mDirty[i] = 0; end
    repeat (3) step();
    rstN = 1'b1;
    // R1: reset state
    check("R1 done low after reset", int'(victimDone), 0);
    check("R1 busy low after reset", int'(busy), 0);
    doPick(1'b0); // R1: pointer at 0, all flags clear -> frame 0 in one step

    // R2 / R3 / R4 / R5: swept access patterns, alternating modes
    for (int s = 0; s < 24; s++) begin
      for (int i = 0; i < N; i++)
        if (((i*5 + s*3) % 7) < 3) doAccess(i, ((i + s) % 3) == 0);
      doPick(s[0]);
    end

    // R5: everything referenced and dirty -> clean pass fails, fallback sweep
    for (int i = 0; i < N; i++) doAccess(i, 1'b1);
    doPick(1'b1);

    // R7: all dirty, all referenced; plain pick, then clean pick finds old victim
    for (int i = 0; i < N; i++) doAccess(i, 1'b1);
    p = mPtr;
    doPick(1'b0);
    doPick(1'b1);
    check("R7 cleared victim reused as clean frame", int'(victimIdx), p);

    // R8: access collides with the sweep clear on the pointer frame
    for (int i = 0; i < N; i++) doAccess(i, 1'b0);
    p = mPtr;
    reqValid = 1'b1; preferClean = 1'b0;
    step();
    reqValid = 1'b0;
    accValid = 1'b1; accIdx = IW'(p); accWrite = 1'b0;
    step();
    accValid = 1'b0;
    cnt = 2;
    while (!victimDone && cnt < 4*N + 4) begin step(); cnt++; end
    check("R8 victim after collision", int'(victimIdx), (p + 1) % N);
    check("R8 cycles after collision", cnt, N + 3);
    check("R8 victim dirty", int'(victimDirty), mDirty[(p + 1) % N]);
    for (int i = 0; i < N; i++) mRef[i] = 0;
    mDirty[(p + 1) % N] = 0;
    mPtr = (p + 2) % N;
    step();

    // R9: extra request during a search is ignored
    for (int i = 0; i < N; i++) doAccess(i, 1'b0);
    p = mPtr;
    reqValid = 1'b1; preferClean = 1'b0;
    step();
    reqValid = 1'b0;
    step();
    reqValid = 1'b1;
    step();
    reqValid = 1'b0;
    cnt = 3;
    while (!victimDone && cnt < 4*N + 4) begin step(); cnt++; end
    check("R9 victim with request while busy", int'(victimIdx), p);
    check("R9 cycles unaffected", cnt, N + 2);
    begin
      int extra = 0;
      for (int i = 0; i < 3*N; i++) begin
        step();
        if (victimDone || busy) extra++;
      end
      check("R9 no second search", extra, 0);
    end
    for (int i = 0; i < N; i++) mRef[i] = 0;
    mDirty[p] = 0;
    mPtr = (p + 1) % N;
    doPick(1'b1); // R4 resumes after the last victim

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    nChecks++; nFails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule